// File: doc/BRIEF.md
# Grouped-Direction Digital I/O Port

This block is a 64-pin general-purpose digital I/O port controlled through a 16-bit local bus. The level on each pin passes through a two-stage synchronizer and is then captured into an input register that software reads back as four 16-bit words. An output register, also written as four 16-bit words, drives the pin-side data. Each output enable is gated by two things: a direction bit that covers a whole group of eight pins, and a single global enable bit that covers every pin.

A control word holds three bits. The global output enable bit switches every driver on or off together. The hold-outputs bit freezes the pins at their present values. While it is set, bus writes to the output register collect in a shadow copy, and that copy is applied when the bit clears. The lock-inputs bit freezes the input register so that software can read a consistent 64-bit snapshot across several bus reads. Reads are combinational from the word address, and writes take effect at the clock edge on which the write strobe is high.

Top module: `gdio_port`

## Requirements
- R1: After reset every register reads zero. All pin_oe bits and all pin_out bits are zero.
- R2: Input word k (word address k, k = 0..3) returns pin_in[16k+15:16k]. A pin level applied before a clock edge appears in the readback after the third rising edge.
- R3: While control bit 2 (lock inputs) is set, the input words keep the value they held when the lock took effect, whatever the pins do. Once the bit clears, sampling resumes.
- R4: Writing word address 4+k (k = 0..3) stores the data into output register bits [16k+15:16k]. Reading that address returns the stored value.
- R5: Word address 8 holds the 8-bit direction value in bits [7:0]. Bits [15:8] are ignored on write and read as zero. Direction bit n enables pins 8n..8n+7.
- R6: Word address 9 is the control word. Bit 0 is the global output enable. While bit 0 is zero, every pin_oe bit is zero, whatever the direction value.
- R7: pin_oe[i] is one exactly when the global enable is set and the direction bit of pin i's group is set. pin_out[i] equals the applied output data bit ANDed with pin_oe[i].
- R8: While control bit 1 (hold outputs) is set, output-register writes change the readback but leave pin_out unchanged. Once the bit clears, the pins take the buffered value on the next clock edge.
- R9: Word addresses 10 to 15 read as zero, and writes to them change no register.
- R10: When hold is clear, an output-register write reaches pin_out at the same clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 64 | Asynchronous pin levels |
| pin_out | output | 64 | Output data toward the pads, masked by the enables |
| pin_oe | output | 64 | Per-pin output driver enable |
| bus_addr | input | 4 | Local-bus word address |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |

## Verification
The bench sets the lock and then changes the pins. A design that went on sampling while locked would return the new pattern where the old one is expected. It writes the output register while hold is set and checks the pins on the edge just after hold clears. This catches a design that leaks writes through the hold, and also one that never applies the buffered value. It checks pin_out on the edge right after an unheld write, which exposes an extra pipeline stage on the output path. It writes a direction word with the upper byte set and writes to unmapped addresses. A decoder that aliased addresses or kept the upper direction bits would show the effect in the readback or in pin_oe.

// File: rtl/gdio_pkg.sv
// Package: shared constants and types for the grouped-direction I/O port.
// Assumes a 16-bit local bus with word addressing.
package gdio_pkg;

    localparam int BUS_W = 16;

    // Control word layout; the bus decoder and the datapath both rely on it
    typedef struct packed {
        logic lock_in;   // bit 2: freeze input register
        logic hold_out;  // bit 1: freeze pins, buffer writes
        logic oe_en;     // bit 0: global output enable
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/gdio_sync.sv
// Module: multi-stage flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherency is implied.
module gdio_sync #(
    parameter int WIDTH  = 64,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: first capture of the raw pin level
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= d;
                end
            end else begin : g_next
                // Purpose: additional settling stage
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gdio_capture.sv
// Module: input register fed by the synchronizer, with a lock control.
// Assumes lock is a registered control bit; while it is high the register holds.
module gdio_capture #(
    parameter int WIDTH     = 64,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic             lock,
    output logic [WIDTH-1:0] in_q
);

    logic [WIDTH-1:0] pin_sync;

    gdio_sync #(
        .WIDTH  (WIDTH),
        .STAGES (SYNC_DEPTH)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    // Purpose: sample synchronized pins unless inputs are locked
    always_ff @(posedge clk) begin
        if (!rst_n)     in_q <= '0;
        else if (!lock) in_q <= pin_sync;
    end

endmodule

// File: rtl/gdio_drive.sv
// Module: applied output data and per-pin enables.
// Assumes shadow_nxt already carries a same-cycle bus write; hold freezes the
// applied data, and enables are expanded from one bit per group.
module gdio_drive #(
    parameter int NUM_GROUPS = 8,
    parameter int GROUP_W    = 8,
    localparam int PIN_W     = NUM_GROUPS * GROUP_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PIN_W-1:0]      shadow_nxt,
    input  logic                  hold,
    input  logic                  oe_en,
    input  logic [NUM_GROUPS-1:0] dir_q,
    output logic [PIN_W-1:0]      live_q,
    output logic [PIN_W-1:0]      pin_out,
    output logic [PIN_W-1:0]      pin_oe
);

    // Purpose: apply buffered output data whenever hold is released
    always_ff @(posedge clk) begin
        if (!rst_n)     live_q <= '0;
        else if (!hold) live_q <= shadow_nxt;
    end

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            // Purpose: one direction bit plus global enable drive a whole group
            assign pin_oe[g*GROUP_W +: GROUP_W] = {GROUP_W{oe_en & dir_q[g]}};
        end
    endgenerate

    assign pin_out = live_q & pin_oe;

endmodule

// File: rtl/gdio_regs.sv
// Module: local-bus register file: output shadow, direction, control, readback.
// Assumes word addressing; input words at 0.., output words next, then
// direction, then control; every other address reads zero and ignores writes.
module gdio_regs
    import gdio_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int GROUP_W    = 8,
    parameter int ADDR_W     = 4,
    localparam int PIN_W     = NUM_GROUPS * GROUP_W,
    localparam int WORDS     = PIN_W / BUS_W,
    localparam int IN_BASE   = 0,
    localparam int OUT_BASE  = WORDS,
    localparam int DIR_ADDR  = 2 * WORDS,
    localparam int CTRL_ADDR = 2 * WORDS + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    input  logic [PIN_W-1:0]      in_q,
    output logic [PIN_W-1:0]      shadow_nxt,
    output logic [NUM_GROUPS-1:0] dir_q,
    output ctrl_t                 ctrl_q
);

    logic [PIN_W-1:0] shadow_q;
    logic             dir_hit;
    logic             ctrl_hit;

    assign dir_hit  = (bus_addr == ADDR_W'(DIR_ADDR));
    assign ctrl_hit = (bus_addr == ADDR_W'(CTRL_ADDR));

    // Purpose: merge a bus write into the next output shadow value
    always_comb begin
        shadow_nxt = shadow_q;
        for (int k = 0; k < WORDS; k++) begin
            if (bus_wr && bus_addr == ADDR_W'(OUT_BASE + k))
                shadow_nxt[k*BUS_W +: BUS_W] = bus_wdata;
        end
    end

    // Purpose: store the output shadow
    always_ff @(posedge clk) begin
        if (!rst_n) shadow_q <= '0;
        else        shadow_q <= shadow_nxt;
    end

    // Purpose: store the direction bits (upper data bits dropped)
    always_ff @(posedge clk) begin
        if (!rst_n)                dir_q <= '0;
        else if (bus_wr && dir_hit) dir_q <= bus_wdata[NUM_GROUPS-1:0];
    end

    // Purpose: store the control word
    always_ff @(posedge clk) begin
        if (!rst_n)                 ctrl_q <= '0;
        else if (bus_wr && ctrl_hit) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    // Purpose: combinational read multiplexer
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < WORDS; k++) begin
            if (bus_addr == ADDR_W'(IN_BASE + k))
                bus_rdata = in_q[k*BUS_W +: BUS_W];
            if (bus_addr == ADDR_W'(OUT_BASE + k))
                bus_rdata = shadow_q[k*BUS_W +: BUS_W];
        end
        if (dir_hit)  bus_rdata = BUS_W'(dir_q);
        if (ctrl_hit) bus_rdata = BUS_W'(ctrl_q);
    end

endmodule

// File: rtl/gdio_port.sv
// Module: top of the grouped-direction digital I/O port.
// Assumes pin_in is asynchronous and the bus is synchronous to clk.
module gdio_port
    import gdio_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int GROUP_W    = 8,
    parameter int ADDR_W     = 4,
    parameter int SYNC_DEPTH = 2,
    localparam int PIN_W     = NUM_GROUPS * GROUP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata
);

    logic [PIN_W-1:0]      in_q;
    logic [PIN_W-1:0]      shadow_nxt;
    logic [PIN_W-1:0]      live_q;
    logic [NUM_GROUPS-1:0] dir_q;
    ctrl_t                 ctrl_q;
    logic                  oe_en_w;
    logic                  hold_w;
    logic                  lock_w;

    assign oe_en_w = ctrl_q.oe_en;
    assign hold_w  = ctrl_q.hold_out;
    assign lock_w  = ctrl_q.lock_in;

    gdio_regs #(
        .NUM_GROUPS (NUM_GROUPS),
        .GROUP_W    (GROUP_W),
        .ADDR_W     (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .in_q       (in_q),
        .shadow_nxt (shadow_nxt),
        .dir_q      (dir_q),
        .ctrl_q     (ctrl_q)
    );

    gdio_capture #(
        .WIDTH      (PIN_W),
        .SYNC_DEPTH (SYNC_DEPTH)
    ) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .lock   (lock_w),
        .in_q   (in_q)
    );

    gdio_drive #(
        .NUM_GROUPS (NUM_GROUPS),
        .GROUP_W    (GROUP_W)
    ) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .shadow_nxt (shadow_nxt),
        .hold       (hold_w),
        .oe_en      (oe_en_w),
        .dir_q      (dir_q),
        .live_q     (live_q),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

endmodule

// File: rtl/gdio_port_chk.sv
// Module: property checker for gdio_port, attached with bind.
// Assumes it sees the top's ports and its internal control/data nets.
module gdio_port_chk #(
    parameter int NUM_GROUPS = 8,
    parameter int GROUP_W    = 8,
    localparam int PIN_W     = NUM_GROUPS * GROUP_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PIN_W-1:0] pin_out,
    input logic [PIN_W-1:0] pin_oe,
    input logic [PIN_W-1:0] in_q,
    input logic [PIN_W-1:0] live_q,
    input logic             oe_en_w,
    input logic             hold_w,
    input logic             lock_w
);

    // R3
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_w) |-> (in_q == $past(in_q)));

    // R8
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold_w) |-> (live_q == $past(live_q)));

    // R6
    global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_en_w |-> (pin_oe == '0));

    // R7
    masked_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0));

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            // R5
            group_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (pin_oe[g*GROUP_W +: GROUP_W] == '0) ||
                (pin_oe[g*GROUP_W +: GROUP_W] == '1));
        end
    endgenerate

endmodule

bind gdio_port gdio_port_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_W    (GROUP_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .in_q    (in_q),
    .live_q  (live_q),
    .oe_en_w (oe_en_w),
    .hold_w  (hold_w),
    .lock_w  (lock_w)
);

// File: tb/test_gdio_port.sv
// Bench: scoreboard for gdio_port. Driver tasks push expected items into a
// queue; a monitor pops and compares them on the falling clock edge.
module test_gdio_port;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        bit          is_pin;
        logic [3:0]  addr;
        logic [63:0] exp_a;
        logic [63:0] exp_b;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pin_in = '0;
    logic [63:0] pin_out;
    logic [63:0] pin_oe;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    item_t       sb_q[$];
    logic        chk_strobe = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;

    // Bench-side model of the register state
    logic [63:0] m_shadow = '0;
    logic [63:0] m_live = '0;
    logic [7:0]  m_dir = '0;
    logic [2:0]  m_ctrl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gdio_port i_gdio_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // Monitor: pops one expected item per strobe and compares
    always @(negedge clk) begin
        if (chk_strobe && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (!it.is_pin) begin
                if (bus_rdata !== it.exp_a[15:0]) begin
                    n_fail++;
                    $display("FAIL %s: addr %0d read %h expected %h",
                             it.tag, it.addr, bus_rdata, it.exp_a[15:0]);
                end
            end else begin
                if (pin_oe !== it.exp_a || pin_out !== it.exp_b) begin
                    n_fail++;
                    $display("FAIL %s: oe %h out %h expected oe %h out %h",
                             it.tag, pin_oe, pin_out, it.exp_a, it.exp_b);
                end
            end
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic chk_read(input logic [3:0] a, input logic [15:0] e, input string tag);
        item_t it;
        bus_addr  = a;
        it.is_pin = 1'b0;
        it.addr   = a;
        it.exp_a  = {48'd0, e};
        it.exp_b  = '0;
        it.tag    = tag;
        sb_q.push_back(it);
        chk_strobe = 1'b1;
        @(negedge clk);
        #1 chk_strobe = 1'b0;
    endtask

    task automatic chk_pins(input string tag);
        item_t it;
        logic [63:0] oe;
        for (int g = 0; g < 8; g++)
            oe[g*8 +: 8] = {8{m_ctrl[0] & m_dir[g]}};
        it.is_pin = 1'b1;
        it.addr   = '0;
        it.exp_a  = oe;
        it.exp_b  = m_live & oe;
        it.tag    = tag;
        sb_q.push_back(it);
        chk_strobe = 1'b1;
        @(negedge clk);
        #1 chk_strobe = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R1: watchdog expired, actual running expected done");
        finish_run();
    end

    // Stimulus
    initial begin
        logic [63:0] pat_a;
        logic [63:0] pat_c;
        pat_a = 64'h0123_4567_89AB_CDEF;
        pat_c = 64'hF00D_C0DE_5A5A_3C3C;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 10; a++) chk_read(4'(a), 16'h0, "R1 reset");
        chk_pins("R1 reset pins");

        // R2: input capture after three edges
        pin_in = pat_a;
        repeat (3) @(posedge clk);
        #1;
        for (int k = 0; k < 4; k++) chk_read(4'(k), pat_a[k*16 +: 16], "R2 input word");

        // R3: lock holds snapshot, release resumes
        bus_write(4'd9, 16'h0004);
        m_ctrl = 3'b100;
        pin_in = ~pat_a;
        repeat (4) @(posedge clk);
        #1;
        for (int k = 0; k < 4; k++) chk_read(4'(k), pat_a[k*16 +: 16], "R3 locked");
        bus_write(4'd9, 16'h0000);
        m_ctrl = 3'b000;
        repeat (4) @(posedge clk);
        #1;
        for (int k = 0; k < 4; k++) chk_read(4'(k), ~pat_a[k*16 +: 16], "R3 unlocked");

        // R4: output register write and readback; R6 enables still off
        for (int k = 0; k < 4; k++) bus_write(4'(4 + k), pat_c[k*16 +: 16]);
        m_shadow = pat_c;
        m_live   = pat_c;
        for (int k = 0; k < 4; k++) chk_read(4'(4 + k), pat_c[k*16 +: 16], "R4 out word");
        chk_pins("R6 global off");

        // R5 / R7: direction groups with global enable
        bus_write(4'd8, 16'h000F);
        m_dir = 8'h0F;
        bus_write(4'd9, 16'h0001);
        m_ctrl = 3'b001;
        chk_pins("R7 low groups");
        chk_read(4'd8, 16'h000F, "R5 dir read");
        bus_write(4'd8, 16'hA5F0);
        m_dir = 8'hF0;
        chk_read(4'd8, 16'h00F0, "R5 upper bits dropped");
        chk_pins("R5 high groups");

        // R6: global enable off overrides direction
        bus_write(4'd8, 16'h00FF);
        m_dir = 8'hFF;
        bus_write(4'd9, 16'h0000);
        m_ctrl = 3'b000;
        chk_pins("R6 all dir but disabled");
        bus_write(4'd9, 16'h0001);
        m_ctrl = 3'b001;
        chk_pins("R7 all groups");

        // R8: hold buffers writes
        bus_write(4'd9, 16'h0003);
        m_ctrl = 3'b011;
        bus_write(4'd4, 16'hBEEF);
        m_shadow[15:0] = 16'hBEEF;
        chk_pins("R8 held pins");
        chk_read(4'd4, 16'hBEEF, "R8 shadow read");
        bus_write(4'd9, 16'h0001);
        m_ctrl = 3'b001;
        chk_pins("R8 still held at release edge");
        @(posedge clk);
        #1;
        m_live = m_shadow;
        chk_pins("R8 applied after release");

        // R10: unheld write reaches pins at its own edge
        bus_write(4'd5, 16'h1234);
        m_shadow[31:16] = 16'h1234;
        m_live = m_shadow;
        chk_pins("R10 same-edge update");

        // R9: unmapped addresses
        bus_write(4'd12, 16'hFFFF);
        bus_write(4'd15, 16'hFFFF);
        chk_read(4'd12, 16'h0000, "R9 unmapped read");
        chk_read(4'd9, 16'h0001, "R9 ctrl untouched");
        chk_read(4'd8, 16'h00FF, "R9 dir untouched");
        chk_pins("R9 pins untouched");

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule